// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter and Receiver

This block is a small asynchronous serial port on a 32-bit register port. Software writes bytes to a data register and reads received bytes from the same offset. A status register at the next word reports whether a received byte is waiting, whether the transmit path can take more data, and whether a received byte was lost. The block drives a single serial output and samples a single serial input, both idle high. It uses fixed frames: one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts `BAUD_CLKS` clock cycles.

The transmit side has two stages. A holding byte sits in front of the shift register, so software can queue a second byte while the first one is on the line. The queued byte leaves back to back with the first. The receive side keeps a single byte. When a new byte arrives before the old one was read, the new byte replaces the old one and a sticky overrun flag is set. Each accepted received byte and each finished transmit frame gives a one-cycle pulse on the interrupt output.

Top module: `uart_dbuf`

## Requirements
- R1: After reset the status register (offset 0x074) reads 0x006: bit 1 (shift stage empty) and bit 2 (holding stage empty) are set, and bit 0 (byte ready) and bit 4 (overrun) are clear. `txOut` is high and `irq` is low.
- R2: A write to the data register (offset 0x070) while status bit 1 is set loads bits 7:0 into the shift stage and clears bit 1. The start bit appears on `txOut` in the cycle after the write edge.
- R3: A data write while status bit 1 is clear stores the byte in the holding stage and clears status bit 2.
- R4: When a frame ends and the holding stage is full, the held byte starts at once with no idle gap, and bit 2 is set. When the holding stage is empty, bit 1 is set. Bytes leave in the order they were written.
- R5: A transmitted frame is a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts `BAUD_CLKS` clocks. The line is high between frames.
- R6: A correctly framed received byte sets status bit 0 and can be read in bits 7:0 of the data register. If bit 0 was already set, status bit 4 is set and the new byte replaces the old one.
- R7: A read of the data register clears status bit 0.
- R8: Any write to the status register clears status bits 1, 2 and 4 and leaves bit 0 unchanged.
- R9: `irq` is high for exactly one cycle for each accepted received byte and for each completed transmit frame.
- R10: A low level on `rxIn` that is high again at the middle of the start bit is ignored. It changes no status and gives no `irq`.
- R11: A received frame whose stop bit samples low is discarded. It changes neither status nor data and gives no `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; a data read has a side effect at the clock edge |
| addr | input | ADDR_W | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` while `rdEn` is high |
| rxIn | input | 1 | Serial input, idle high |
| txOut | output | 1 | Serial output, idle high |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong flag shows up at the ports in one of two ways.
- A stuck empty flag sends a queued byte into the shift stage too early, which corrupts the frame being sent.
- A lost holding byte drops that byte from the line.

The status word shows both cases in the cycle after the write, and the decoded line shows them within one frame time.

Other faults also show within a frame:
- A receiver that is off by one bit or samples at the wrong phase gives the wrong byte.
- A receiver that skips the stop-bit or start-bit check raises a false ready flag or an extra interrupt pulse within one frame time.

The bench also places a second write at random distances from the end of a frame, so that it can land on the cycle where the holding stage drains.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;

  localparam int unsigned BYTE_W = 8;

  // status bit positions (decoded by software)
  localparam int unsigned ST_READY = 0;
  localparam int unsigned ST_SHIFT_EMPTY = 1;
  localparam int unsigned ST_HOLD_EMPTY = 2;
  localparam int unsigned ST_OVERRUN = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic txStart;
    logic [BYTE_W-1:0] txByte;
  } ctlStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic txDone;
    logic rxValid;
    logic [BYTE_W-1:0] rxByte;
  } dpEvent_t;

endpackage

// File: rtl/uart_dbuf_dp.sv
module uart_dbuf_dp
  import uart_dbuf_pkg::*;
#(
  parameter int unsigned BAUD_CLKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output dpEvent_t   evt,
  input  logic       rxIn,
  output logic       txOut
);

  localparam int unsigned CW = (BAUD_CLKS > 2) ? $clog2(BAUD_CLKS) : 1;
  localparam int unsigned HALF = BAUD_CLKS / 2;
  localparam int unsigned FRAME_BITS = BYTE_W + 2;
  localparam int unsigned BW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST_TICK = CW'(BAUD_CLKS - 1);
  localparam logic [CW-1:0] MID_TICK = CW'(HALF - 1);
  localparam logic [BW-1:0] STOP_IDX = BW'(FRAME_BITS - 1);

  // ---------------- transmitter ----------------
  logic [FRAME_BITS-1:0] txShift;
  logic txActive;
  logic [CW-1:0] txCnt;
  logic [BW-1:0] txBit;
  logic txDone;

  assign txDone = txActive && (txCnt == LAST_TICK) && (txBit == STOP_IDX);
  assign txOut = txActive ? txShift[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      txActive <= 1'b0;
      txCnt <= '0;
      txBit <= '0;
    end else if (ctl.txStart) begin
      txShift <= {1'b1, ctl.txByte, 1'b0};
      txActive <= 1'b1;
      txCnt <= '0;
      txBit <= '0;
    end else if (txActive) begin
      if (txCnt == LAST_TICK) begin
        txCnt <= '0;
        if (txBit == STOP_IDX) begin
          txActive <= 1'b0;
        end else begin
          txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
          txBit <= txBit + 1'b1;
        end
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // ---------------- receiver ----------------
  logic [2:0] rxSync;
  logic rxLine;
  logic rxBusy;
  logic [CW-1:0] rxCnt;
  logic [BW-1:0] rxBit;
  logic [BYTE_W-1:0] rxShift;
  logic rxValidR;
  logic [BYTE_W-1:0] rxByteR;

  assign rxLine = rxSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= '1;
      rxBusy <= 1'b0;
      rxCnt <= '0;
      rxBit <= '0;
      rxShift <= '0;
      rxValidR <= 1'b0;
      rxByteR <= '0;
    end else begin
      rxSync <= {rxSync[1:0], rxIn};
      rxValidR <= 1'b0;
      if (!rxBusy) begin
        // a start is a falling edge only, so a held-low line never retriggers
        if (rxSync[2] && !rxLine) begin
          rxBusy <= 1'b1;
          rxCnt <= '0;
          rxBit <= '0;
        end
      end else if (rxBit == '0) begin
        if (rxCnt == MID_TICK) begin
          rxCnt <= '0;
          if (rxLine) rxBusy <= 1'b0;  // false start
          else rxBit <= 1'b1;
        end else begin
          rxCnt <= rxCnt + 1'b1;
        end
      end else if (rxCnt == LAST_TICK) begin
        rxCnt <= '0;
        if (rxBit == STOP_IDX) begin
          rxBusy <= 1'b0;
          if (rxLine) begin
            rxValidR <= 1'b1;
            rxByteR <= rxShift;
          end
        end else begin
          rxShift <= {rxLine, rxShift[BYTE_W-1:1]};
          rxBit <= rxBit + 1'b1;
        end
      end else begin
        rxCnt <= rxCnt + 1'b1;
      end
    end
  end

  assign evt.txDone = txDone;
  assign evt.rxValid = rxValidR;
  assign evt.rxByte = rxByteR;

  // control must never restart a frame in flight
  assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txStart |-> (!txActive || txDone));
  // last cycle of every frame is the high stop bit
  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txOut);
  // a byte is only delivered after a high stop sample
  assert_good_stop_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxValidR |-> $past(rxLine));

endmodule

// File: rtl/uart_dbuf_ctrl.sv
module uart_dbuf_ctrl
  import uart_dbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DATA_OFF = 'h070,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h074
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  dpEvent_t          evt,
  output ctlStrobe_t        ctl,
  output logic              irq
);

  logic dataReady, shiftEmpty, holdEmpty, overrun;
  logic [BYTE_W-1:0] holdReg;
  logic [BYTE_W-1:0] rxData;
  logic wrDat, wrStat, rdDat;
  logic [31:0] statWord;

  assign wrDat = wrEn && (addr == DATA_OFF);
  assign wrStat = wrEn && (addr == STAT_OFF);
  assign rdDat = rdEn && (addr == DATA_OFF);

  // pick the byte that enters the shift stage this cycle, if any
  always_comb begin
    ctl = '0;
    if (wrDat && shiftEmpty) begin
      ctl.txStart = 1'b1;
      ctl.txByte = wrData[BYTE_W-1:0];
    end else if (evt.txDone && !holdEmpty) begin
      ctl.txStart = 1'b1;
      ctl.txByte = holdReg;
    end else if (evt.txDone && wrDat) begin
      // write lands on the closing cycle of a frame with nothing held
      ctl.txStart = 1'b1;
      ctl.txByte = wrData[BYTE_W-1:0];
    end
  end

  always_comb begin
    statWord = '0;
    statWord[ST_READY] = dataReady;
    statWord[ST_SHIFT_EMPTY] = shiftEmpty;
    statWord[ST_HOLD_EMPTY] = holdEmpty;
    statWord[ST_OVERRUN] = overrun;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == DATA_OFF) rdData = {{(32 - BYTE_W){1'b0}}, rxData};
      else if (addr == STAT_OFF) rdData = statWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReady <= 1'b0;
      shiftEmpty <= 1'b1;
      holdEmpty <= 1'b1;
      overrun <= 1'b0;
      holdReg <= '0;
      rxData <= '0;
      irq <= 1'b0;
    end else begin
      if (wrStat) begin
        shiftEmpty <= 1'b0;
        holdEmpty <= 1'b0;
        overrun <= 1'b0;
      end
      // frame end: drain holding stage or go idle
      if (evt.txDone) begin
        if (!holdEmpty) holdEmpty <= 1'b1;
        else if (!wrDat) shiftEmpty <= 1'b1;
      end
      if (wrDat) begin
        if (shiftEmpty) begin
          shiftEmpty <= 1'b0;
        end else if (!(evt.txDone && holdEmpty)) begin
          holdReg <= wrData[BYTE_W-1:0];
          holdEmpty <= 1'b0;
        end
      end
      if (rdDat) dataReady <= 1'b0;
      if (evt.rxValid) begin
        rxData <= evt.rxByte;
        dataReady <= 1'b1;
        if (dataReady) overrun <= 1'b1;
      end
      irq <= evt.txDone | evt.rxValid;
    end
  end

  assert_hold_needs_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    !holdEmpty |-> !shiftEmpty);
  assert_rx_sets_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    evt.rxValid |=> dataReady);
  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evt.rxValid && dataReady) |=> overrun);
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdDat && !evt.rxValid) |=> !dataReady);
  assert_stat_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && !evt.txDone && !evt.rxValid) |=> (!overrun && !holdEmpty && !shiftEmpty && $stable(dataReady)));
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (evt.txDone || evt.rxValid) |=> irq);

endmodule

// File: rtl/uart_dbuf.sv
module uart_dbuf
  import uart_dbuf_pkg::*;
#(
  parameter int unsigned BAUD_CLKS = 16,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DATA_OFF = 'h070,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h074
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              rxIn,
  output logic              txOut,
  output logic              irq
);

  ctlStrobe_t ctl;
  dpEvent_t evt;

  uart_dbuf_ctrl #(
    .ADDR_W(ADDR_W), .DATA_OFF(DATA_OFF), .STAT_OFF(STAT_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evt(evt), .ctl(ctl), .irq(irq)
  );

  uart_dbuf_dp #(.BAUD_CLKS(BAUD_CLKS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .evt(evt), .rxIn(rxIn), .txOut(txOut)
  );

endmodule

// File: tb/tb_uart_dbuf.sv
module tb_uart_dbuf;

  localparam int CLK_PERIOD = 10;
  localparam int BAUD = 16;
  localparam logic [11:0] A_DATA = 12'h070;
  localparam logic [11:0] A_STAT = 12'h074;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic rxIn = 1'b1;
  logic txOut, irq;

  int checks = 0, fails = 0;
  int irqCnt = 0;
  logic [7:0] txGot [0:63];
  logic [7:0] txExp [0:63];
  int txGotCnt = 0, txExpCnt = 0;
  logic [7:0] decByte;

  uart_dbuf #(.BAUD_CLKS(BAUD)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxIn(rxIn), .txOut(txOut), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) if (rstN && irq) irqCnt++;

  function automatic logic [31:0] expStat(input logic rdy, input logic she,
                                          input logic hle, input logic ovr);
    return {27'b0, ovr, 1'b0, hle, she, rdy};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b, input logic stopLvl);
    @(negedge clk);
    rxIn = 1'b0;
    repeat (BAUD) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      repeat (BAUD) @(negedge clk);
    end
    rxIn = stopLvl;
    repeat (BAUD) @(negedge clk);
    rxIn = 1'b1;
    repeat (BAUD) @(negedge clk);
  endtask

  task automatic waitTxIdle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      regRead(A_STAT, s);
      if (s[2:1] == 2'b11) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic queueTx(input logic [7:0] b);
    txExp[txExpCnt] = b;
    txExpCnt++;
    regWrite(A_DATA, {24'h0, b});
  endtask

  // line decoder for txOut, sampling mid-bit
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txOut === 1'b0) begin
        repeat (BAUD / 2) @(negedge clk);
        check("R5 start bit low", {31'b0, txOut}, 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (BAUD) @(negedge clk);
          decByte[i] = txOut;
        end
        repeat (BAUD) @(negedge clk);
        check("R5 stop bit high", {31'b0, txOut}, 32'd1);
        txGot[txGotCnt] = decByte;
        txGotCnt++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int irqBase;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    regRead(A_STAT, rd);
    check("R1 status after reset", rd, expStat(0, 1, 1, 0));
    check("R1 txOut idle", {31'b0, txOut}, 32'd1);
    check("R1 irq low", {31'b0, irq}, 32'd0);

    // R2 / R3 / R4 two queued bytes
    irqBase = irqCnt;
    queueTx(8'hA5);
    check("R2 start bit immediate", {31'b0, txOut}, 32'd0);
    regRead(A_STAT, rd);
    check("R2 shift busy", rd, expStat(0, 0, 1, 0));
    queueTx(8'h3C);
    regRead(A_STAT, rd);
    check("R3 holding full", rd, expStat(0, 0, 0, 0));
    waitTxIdle();
    check("R4 frames sent", txGotCnt, 2);
    check("R4 first byte", {24'h0, txGot[0]}, 32'hA5);
    check("R4 second byte", {24'h0, txGot[1]}, 32'h3C);
    regRead(A_STAT, rd);
    check("R4 both empty", rd, expStat(0, 1, 1, 0));
    check("R9 irq per tx frame", irqCnt - irqBase, 2);

    // R6 / R7 single receive
    irqBase = irqCnt;
    sendRx(8'h5A, 1'b1);
    regRead(A_STAT, rd);
    check("R6 ready set", rd, expStat(1, 1, 1, 0));
    check("R9 irq per rx byte", irqCnt - irqBase, 1);
    regRead(A_DATA, rd);
    check("R6 data value", rd, 32'h5A);
    regRead(A_STAT, rd);
    check("R7 ready cleared", rd, expStat(0, 1, 1, 0));

    // R6 overrun
    sendRx(8'h11, 1'b1);
    sendRx(8'h22, 1'b1);
    regRead(A_STAT, rd);
    check("R6 overrun flag", rd, expStat(1, 1, 1, 1));
    regRead(A_DATA, rd);
    check("R6 newer byte kept", rd, 32'h22);

    // R11 bad stop bit
    irqBase = irqCnt;
    sendRx(8'h77, 1'b0);
    regRead(A_STAT, rd);
    check("R11 status unchanged", rd, expStat(0, 1, 1, 1));
    regRead(A_DATA, rd);
    check("R11 data unchanged", rd, 32'h22);
    check("R11 no irq", irqCnt - irqBase, 0);

    // R10 short low glitch
    irqBase = irqCnt;
    @(negedge clk);
    rxIn = 1'b0;
    repeat (3) @(negedge clk);
    rxIn = 1'b1;
    repeat (BAUD * 12) @(negedge clk);
    regRead(A_STAT, rd);
    check("R10 glitch ignored", rd, expStat(0, 1, 1, 1));
    check("R10 no irq", irqCnt - irqBase, 0);

    // random receive traffic
    for (int i = 0; i < 12; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      sendRx(b, 1'b1);
      regRead(A_DATA, rd);
      check("R6 random rx byte", rd, {24'h0, b});
      regRead(A_STAT, rd);
      check("R7 random rx cleared", rd, expStat(0, 1, 1, 1));
    end

    // random transmit pairs, second write at random offsets incl. frame end
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b1, b2;
      int gap;
      b1 = 8'($urandom);
      b2 = 8'($urandom);
      gap = (i < 3) ? (BAUD * 10 - 3 + i) : int'($urandom_range(0, BAUD * 12));
      queueTx(b1);
      repeat (gap) @(negedge clk);
      queueTx(b2);
      waitTxIdle();
      check("R4 random frame count", txGotCnt, txExpCnt);
      check("R4 random first", {24'h0, txGot[txGotCnt - 2]}, {24'h0, txExp[txExpCnt - 2]});
      check("R4 random second", {24'h0, txGot[txGotCnt - 1]}, {24'h0, txExp[txExpCnt - 1]});
    end

    // R8 status write keeps ready, clears the rest
    sendRx(8'hC3, 1'b1);
    regWrite(A_STAT, 32'hFFFF_FFFF);
    regRead(A_STAT, rd);
    check("R8 only ready survives", rd, expStat(1, 0, 0, 0));
    regRead(A_DATA, rd);
    check("R8 data intact", rd, 32'hC3);
    regRead(A_STAT, rd);
    check("R7 ready cleared after status write", rd, expStat(0, 0, 0, 0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule